// File: doc/BRIEF.md
# PCI Error and Event Interrupt Aggregator

This block collects the interrupt sources of a PCI bus controller and turns them into a fixed set of request lines for the CPU interrupt controller. The request lines are a system-error request, a general error request, a power-down request, a power-on request and one completion request for each DMA channel. It also reports the index of the most urgent active request, together with a valid flag.

System-error handling depends on the controller's role, which is set by a mode strap. In host mode the block samples the incoming active-low SERR# pin and turns a high-to-low transition into a sticky CPU request. In non-host mode it signals the error on the bus instead. It drives the open-drain SERR# pin low for one clock when software raises its system-error bit or when the target logic reports an address parity error. An enable bit gates this output.

Requests that hold state are cleared by one-cycle write-one-to-clear strobes. The general error request is combinational: it reflects the masked pending bits of two error status registers. All pins are plain control and status levels or pulses, so the block has no streaming interface and no back-pressure.

Top module: `pci_irq_agg`

## Requirements
- R1: While reset is held and right after it, `irq` is all zero, `top_valid` is 0 and `serr_oe` is 0.
- R2: In host mode, a falling edge on `serr_n_in` passes through two synchronizer flops and an edge detector. It sets `irq[0]` on the third rising clock edge after the pin goes low, and not before. `irq[0]` then stays set until a `clr_serr` pulse.
- R3: In non-host mode, a falling edge on `serr_n_in` never sets `irq[0]`.
- R4: In non-host mode with `serr_en`=1, a 0-to-1 change of `sw_serr` makes `serr_oe` high for exactly one cycle, starting at the next clock edge. A `sw_serr` that is held high causes no further assertion.
- R5: In non-host mode with `serr_en`=1, a one-cycle `apar_err` pulse makes `serr_oe` high for exactly one cycle, starting at the next clock edge.
- R6: `serr_oe` stays 0 whenever `serr_en` is 0, and whenever `host_mode` is 1, whatever `sw_serr` and `apar_err` do.
- R7: `irq[1]` is the OR over both registers of pending AND mask (`gen_pend & gen_mask`, `arb_pend & arb_mask`). It follows its inputs combinationally.
- R8: `irq[2]` equals `pwr_down_req` and `irq[3]` equals `pwr_on_req`, combinationally.
- R9: A one-cycle pulse on `dma_done[k]` sets `irq[4+k]` at the next edge. The bit holds until a `clr_dma[k]` pulse. If a set and a clear arrive in the same cycle, the set wins.
- R10: The bit order of `irq` is the priority order: bit 0 is the highest and bit 7 the lowest. `top_idx` gives the lowest set bit of `irq`. `top_valid` is 1 exactly when any bit of `irq` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 1 | 1 = controller is bus host |
| serr_n_in | input | 1 | Sampled SERR# pin level (active low) |
| sw_serr | input | 1 | Software system-error control bit |
| apar_err | input | 1 | Address parity error pulse from target logic |
| serr_en | input | 1 | System-error output enable from configuration space |
| gen_pend | input | GEN_W | Pending bits of the general error register |
| gen_mask | input | GEN_W | Enable bits of the general error register |
| arb_pend | input | ARB_W | Pending bits of the arbiter error register |
| arb_mask | input | ARB_W | Enable bits of the arbiter error register |
| pwr_down_req | input | 1 | Power-down request level |
| pwr_on_req | input | 1 | Power-on request level |
| dma_done | input | DMA_N | Per-channel DMA completion pulses |
| clr_serr | input | 1 | Write-one-to-clear strobe for the system-error request |
| clr_dma | input | DMA_N | Write-one-to-clear strobes for the DMA requests |
| serr_oe | output | 1 | Drive SERR# low when 1; release when 0 |
| irq | output | 4+DMA_N | Request lines, bit 0 highest priority |
| top_idx | output | clog2(4+DMA_N) | Index of the highest-priority active request |
| top_valid | output | 1 | Any request active |

## Verification
The bench builds the block with its default parameters: eight general error bits, four arbiter error bits and four DMA channels. These are the sizes of the eight-request layout. With them the top bit of each error register, the eight-entry priority chain and the 3-bit index can all be reached. The vector table covers masking on both registers and priority among the error and power requests. Directed sequences cover the cycle on which the synchronized SERR# detection lands, the one-cycle pin drive, its gating by role and enable, and set-versus-clear collisions on the DMA bits.

// File: rtl/pci_irq_pkg.sv
package pci_irq_pkg;
  localparam int unsigned REQ_SERR  = 0;
  localparam int unsigned REQ_ERR   = 1;
  localparam int unsigned REQ_PDN   = 2;
  localparam int unsigned REQ_PON   = 3;
  localparam int unsigned REQ_DMA0  = 4;
  localparam int unsigned SYNC_LEN  = 2;
endpackage

// File: rtl/pci_serr_sense.sv
module pci_serr_sense #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic serr_n_in,
  output logic fall
);
  // sh[STAGES-1] is the synchronized level; sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], serr_n_in};
  end

  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/pci_serr_drive.sv
module pci_serr_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic host_mode,
  input  logic sw_serr,
  input  logic apar_err,
  input  logic serr_en,
  output logic serr_oe
);
  logic sw_q;
  logic trig;

  assign trig = (sw_serr & ~sw_q) | apar_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q    <= 1'b0;
      serr_oe <= 1'b0;
    end else begin
      sw_q    <= sw_serr;
      serr_oe <= trig & serr_en & ~host_mode;
    end
  end
endmodule

// File: rtl/pci_err_merge.sv
module pci_err_merge #(
  parameter int GEN_W = 8,
  parameter int ARB_W = 4
) (
  input  logic [GEN_W-1:0] gen_pend,
  input  logic [GEN_W-1:0] gen_mask,
  input  logic [ARB_W-1:0] arb_pend,
  input  logic [ARB_W-1:0] arb_mask,
  output logic             err
);
  assign err = (|(gen_pend & gen_mask)) | (|(arb_pend & arb_mask));
endmodule

// File: rtl/pci_req_prio.sv
module pci_req_prio #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          valid
);
  always_comb begin
    idx   = '0;
    valid = |req;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pci_irq_agg.sv
module pci_irq_agg
  import pci_irq_pkg::*;
#(
  parameter int GEN_W = 8,
  parameter int ARB_W = 4,
  parameter int DMA_N = 4,
  localparam int NREQ  = REQ_DMA0 + DMA_N,
  localparam int IDX_W = $clog2(NREQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_mode,
  input  logic             serr_n_in,
  input  logic             sw_serr,
  input  logic             apar_err,
  input  logic             serr_en,
  input  logic [GEN_W-1:0] gen_pend,
  input  logic [GEN_W-1:0] gen_mask,
  input  logic [ARB_W-1:0] arb_pend,
  input  logic [ARB_W-1:0] arb_mask,
  input  logic             pwr_down_req,
  input  logic             pwr_on_req,
  input  logic [DMA_N-1:0] dma_done,
  input  logic             clr_serr,
  input  logic [DMA_N-1:0] clr_dma,
  output logic             serr_oe,
  output logic [NREQ-1:0]  irq,
  output logic [IDX_W-1:0] top_idx,
  output logic             top_valid
);
  logic             serr_fall;
  logic             serr_q;
  logic             err_any;
  logic [DMA_N-1:0] dma_q;

  pci_serr_sense #(.STAGES(SYNC_LEN)) u_sense (
    .clk      (clk),
    .rst_n    (rst_n),
    .serr_n_in(serr_n_in),
    .fall     (serr_fall)
  );

  pci_serr_drive u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_mode(host_mode),
    .sw_serr  (sw_serr),
    .apar_err (apar_err),
    .serr_en  (serr_en),
    .serr_oe  (serr_oe)
  );

  pci_err_merge #(.GEN_W(GEN_W), .ARB_W(ARB_W)) u_merge (
    .gen_pend(gen_pend),
    .gen_mask(gen_mask),
    .arb_pend(arb_pend),
    .arb_mask(arb_mask),
    .err     (err_any)
  );

  // host-only sticky system-error request; set beats clear
  always_ff @(posedge clk) begin
    if (!rst_n) serr_q <= 1'b0;
    else if (serr_fall && host_mode) serr_q <= 1'b1;
    else if (clr_serr) serr_q <= 1'b0;
  end

  for (genvar k = 0; k < DMA_N; k++) begin : g_dma
    always_ff @(posedge clk) begin
      if (!rst_n) dma_q[k] <= 1'b0;
      else if (dma_done[k]) dma_q[k] <= 1'b1;
      else if (clr_dma[k]) dma_q[k] <= 1'b0;
    end
  end

  assign irq = {dma_q, pwr_on_req, pwr_down_req, err_any, serr_q};

  pci_req_prio #(.N(NREQ), .IW(IDX_W)) u_prio (
    .req  (irq),
    .idx  (top_idx),
    .valid(top_valid)
  );
endmodule

// File: rtl/pci_irq_agg_chk.sv
module pci_irq_agg_chk #(
  parameter int DMA_N = 4,
  localparam int NREQ  = 4 + DMA_N,
  localparam int IDX_W = $clog2(NREQ)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_mode,
  input logic             serr_en,
  input logic             clr_serr,
  input logic [DMA_N-1:0] dma_done,
  input logic             serr_oe,
  input logic [NREQ-1:0]  irq,
  input logic [IDX_W-1:0] top_idx,
  input logic             top_valid
);
  a_r4_oe_nonhost: assert property (@(posedge clk) disable iff (!rst_n)
    serr_oe |-> $past(!host_mode));

  a_r6_oe_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    serr_oe |-> $past(serr_en));

  a_r2_serr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq[0] && !clr_serr) |=> irq[0]);

  a_r3_serr_host_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq[0]) |-> $past(host_mode));

  for (genvar k = 0; k < DMA_N; k++) begin : g_dma_chk
    a_r9_dma_set: assert property (@(posedge clk) disable iff (!rst_n)
      dma_done[k] |=> irq[4+k]);
  end

  a_r10_top_is_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid |-> (irq[top_idx] && ((irq & ((NREQ'(1) << top_idx) - NREQ'(1))) == '0)));

  a_r10_valid_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !top_valid |-> (irq == '0));
endmodule

bind pci_irq_agg pci_irq_agg_chk #(.DMA_N(DMA_N)) u_chk (.*);

// File: tb/test_pci_irq_agg.sv
module test_pci_irq_agg;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_mode, serr_n_in, sw_serr, apar_err, serr_en;
  logic [7:0] gen_pend, gen_mask;
  logic [3:0] arb_pend, arb_mask;
  logic       pwr_down_req, pwr_on_req;
  logic [3:0] dma_done, clr_dma;
  logic       clr_serr;
  logic       serr_oe;
  logic [7:0] irq;
  logic [2:0] top_idx;
  logic       top_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pci_irq_agg i_pci_irq_agg (.*);

  // {gp, gm, ap, am, pdn, pon, exp_err, exp_valid, exp_idx}
  localparam int NV = 9;
  localparam logic [30:0] VEC [NV] = '{
    {8'h00, 8'h00, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
    {8'h01, 8'h00, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
    {8'h80, 8'h80, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1},
    {8'h00, 8'h00, 4'h8, 4'h8, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1},
    {8'h00, 8'hff, 4'h8, 4'h7, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
    {8'h00, 8'h00, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd2},
    {8'h00, 8'h00, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd3},
    {8'hff, 8'h01, 4'h0, 4'h0, 1'b1, 1'b1, 1'b1, 1'b1, 3'd1},
    {8'hf0, 8'h0f, 4'h3, 4'hc, 1'b0, 1'b1, 1'b0, 1'b1, 3'd3}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 0; host_mode = 1; serr_n_in = 1; sw_serr = 0; apar_err = 0;
    serr_en = 1; gen_pend = 0; gen_mask = 0; arb_pend = 0; arb_mask = 0;
    pwr_down_req = 0; pwr_on_req = 0; dma_done = 0; clr_dma = 0; clr_serr = 0;
    tick(); tick();
    // R1 reset state
    chk(irq == 0 && !top_valid && !serr_oe, "R1", {irq, top_valid, serr_oe}, 0);
    rst_n = 1;
    tick();
    chk(irq == 0 && !top_valid && !serr_oe, "R1", {irq, top_valid, serr_oe}, 0);

    // R7 R8 R10 vector table
    for (int v = 0; v < NV; v++) begin
      {gen_pend, gen_mask, arb_pend, arb_mask, pwr_down_req, pwr_on_req} = VEC[v][30:5];
      #1;
      chk(irq == {4'b0, VEC[v][5], VEC[v][6], VEC[v][4], 1'b0}, "R7/R8",
          irq, {4'b0, VEC[v][5], VEC[v][6], VEC[v][4], 1'b0});
      chk(top_valid == VEC[v][3] && (!VEC[v][3] || top_idx == VEC[v][2:0]), "R10",
          {top_valid, top_idx}, VEC[v][3:0]);
    end
    gen_pend = 0; gen_mask = 0; arb_pend = 0; arb_mask = 0;
    pwr_down_req = 0; pwr_on_req = 0;
    tick();

    // R9 DMA sticky and priority
    dma_done = 4'b1000; tick(); dma_done = 0;
    chk(irq == 8'h80 && top_idx == 7, "R9", {irq, top_idx}, {8'h80, 3'd7});
    tick();
    chk(irq == 8'h80, "R9 hold", irq, 8'h80);
    dma_done = 4'b0001; tick(); dma_done = 0;
    chk(irq == 8'h90 && top_idx == 4, "R10 dma", {irq, top_idx}, {8'h90, 3'd4});
    clr_dma = 4'b0001; tick(); clr_dma = 0;
    chk(irq == 8'h80 && top_idx == 7, "R9 clear", {irq, top_idx}, {8'h80, 3'd7});
    dma_done = 4'b0010; clr_dma = 4'b0010; tick(); dma_done = 0; clr_dma = 0;
    chk(irq == 8'ha0, "R9 set wins", irq, 8'ha0);
    clr_dma = 4'b1010; tick(); clr_dma = 0;
    chk(irq == 0 && !top_valid, "R9 clear all", irq, 0);

    // R2 host mode SERR# detection
    host_mode = 1; serr_n_in = 0;
    tick(); tick();
    chk(irq[0] == 0, "R2 early", irq[0], 0);
    tick();
    chk(irq[0] == 1 && top_idx == 0, "R2 set", {irq[0], top_idx}, 8);
    serr_n_in = 1; tick(); tick(); tick();
    chk(irq[0] == 1, "R2 sticky", irq[0], 1);
    pwr_down_req = 1; #1;
    chk(top_idx == 0, "R10 serr top", top_idx, 0);
    pwr_down_req = 0;
    clr_serr = 1; tick(); clr_serr = 0;
    chk(irq[0] == 0, "R2 clear", irq[0], 0);

    // R6 host mode never drives
    sw_serr = 1; apar_err = 1; tick(); apar_err = 0; tick();
    chk(!serr_oe, "R6 host", serr_oe, 0);
    sw_serr = 0; tick();

    // R3 non-host ignores pin
    host_mode = 0; serr_n_in = 0;
    tick(); tick(); tick(); tick();
    chk(irq[0] == 0, "R3", irq[0], 0);
    serr_n_in = 1; tick(); tick(); tick();

    // R4 software rise
    sw_serr = 1; tick();
    chk(serr_oe == 1, "R4 assert", serr_oe, 1);
    tick();
    chk(serr_oe == 0, "R4 one cycle", serr_oe, 0);
    tick();
    chk(serr_oe == 0, "R4 held high", serr_oe, 0);
    sw_serr = 0; tick();

    // R5 parity pulse
    apar_err = 1; tick(); apar_err = 0;
    chk(serr_oe == 1, "R5 assert", serr_oe, 1);
    tick();
    chk(serr_oe == 0, "R5 one cycle", serr_oe, 0);

    // R6 enable off
    serr_en = 0; sw_serr = 1; apar_err = 1; tick(); apar_err = 0;
    chk(serr_oe == 0, "R6 disabled", serr_oe, 0);
    tick();
    chk(serr_oe == 0, "R6 disabled", serr_oe, 0);
    sw_serr = 0; serr_en = 1; tick();

    finish_run();
  end
endmodule